// File: doc/BRIEF.md
# Decimating FIR Multiply-Accumulate Cell

This block is one tap of a systolic FIR array. Coefficients enter through a coefficient register and leave, after a delay set by a 2-bit decimation mode, on a coefficient output that feeds the next cell. A broadcast data sample is captured in a data register. Each clock, the product of the held coefficient and the held sample is added into a 26-bit accumulator. The accumulator is exposed so that an external selector can read it.

The coefficient load enable, the data load enable and the reset are all active low. Each is registered inside the cell, so it acts on the second clock edge after it is applied. The reset clears the pipeline registers but leaves the accumulator alone. The accumulator is cleared by an erase strobe, either when the cell is selected or when reset is low at the same time. Each operand can be read either as a 9-bit two's complement value or as an 8-bit unsigned value.

Top module: `fir_mac_cell`

## Requirements
- R1: Products are added into a 26-bit accumulator that wraps modulo 2^26 with no saturation. 1024 additions of 65536 return the accumulator to 0.
- R2: The operand mode bits select how each operand is read. With `coef_signed`/`data_signed` = 1 the operand is 9-bit two's complement. With 0, only bits [7:0] are used as an unsigned value and bit 8 is ignored.
- R3: Loads are enabled on every clock. A coefficient presented before edge E appears on `coef_out` after edge E + `dec_mode`. Modes 0, 1, 2 and 3 therefore give delays of 1, 2, 3 and 4 clocks.
- R4: `coef_ld_n` is registered. The coefficient and decimation registers load on the second edge after it is sampled low, and they hold their values while it is sampled high.
- R5: `data_ld_n` is registered in the same way. The data register loads on the second edge after it is sampled low and holds while it is high.
- R6: A low `rst_n` is registered. On the following edge it clears the coefficient, decimation and data registers to 0. It never changes the accumulator by itself.
- R7: With `erase_n` low and `cell_sel` high, the next edge loads the accumulator with the current product, not with the old sum plus the product. With `erase_n` low and `cell_sel` low (and `rst_n` high), the cell accumulates normally.
- R8: With `erase_n` and `rst_n` both low, the accumulator is loaded with the current product whatever the value of `cell_sel`.
- R9: On every other edge, the accumulator adds the product of the coefficient register and the data register. The multiplier always takes the coefficient register, not the output of the decimation chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the pipeline registers, delayed one clock |
| coef_ld_n | input | 1 | Active-low coefficient load enable, registered |
| data_ld_n | input | 1 | Active-low data load enable, registered |
| coef_signed | input | 1 | 1: coefficient is two's complement, 0: 8-bit unsigned |
| data_signed | input | 1 | 1: data is two's complement, 0: 8-bit unsigned |
| dec_mode | input | 2 | Extra coefficient delay, 0 to 3 clocks |
| coef_in | input | 9 | Coefficient input |
| data_in | input | 9 | Broadcast data sample |
| erase_n | input | 1 | Active-low accumulator clear |
| cell_sel | input | 1 | This cell is the one addressed for erase |
| coef_out | output | 9 | Delayed coefficient to the next cell |
| acc_out | output | 26 | Accumulator value |

## Verification
The tests start with directed patterns.
- A single nonzero coefficient in a stream of zeros is run in each decimation mode. It shows each delay length separately.
- Operands with bit 8 set are checked under both mode settings. This separates a signed reading from an unsigned one.
- Enable and reset pulses are timed one edge apart. This exposes any enable or reset that acts one clock early or late.
- A repeated maximum product tests the wrap.

After these, a long seeded random mix of loads, erases, selects and short resets is compared cycle by cycle with a reference model in the bench. That run covers the interactions between erase, reset and accumulation.

// File: rtl/fir_cell_pkg.sv
// Package: shared constants and the control bundle for the FIR MAC cell.
// Assumes: all users build on these default widths unless they override them.
package fir_cell_pkg;
    localparam int unsigned COEF_W_DEF  = 9;
    localparam int unsigned DATA_W_DEF  = 9;
    localparam int unsigned ACC_W_DEF   = 26;
    localparam int unsigned DEC_MAX_DEF = 3;

    // Registered controls, active high after the one-clock pipeline
    typedef struct packed {
        logic coef_en;
        logic data_en;
        logic pipe_clr;
    } cell_ctrl_t;
endpackage

// File: rtl/fir_ctrl_pipe.sv
// Module: registers the load enables and the reset by one clock.
// Assumes: inputs are synchronous to clk; these flops need no reset of their own.
module fir_ctrl_pipe
    import fir_cell_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       coef_ld_n,
    input  logic       data_ld_n,
    output cell_ctrl_t ctrl
);
    // Sample the active-low controls into an active-high bundle
    always_ff @(posedge clk) begin
        ctrl.coef_en  <= ~coef_ld_n;
        ctrl.data_en  <= ~data_ld_n;
        ctrl.pipe_clr <= ~rst_n;
    end
endmodule

// File: rtl/fir_coef_path.sv
// Module: coefficient register followed by a chain of decimation registers.
// Assumes: the mode value never exceeds DEC_MAX; the whole chain shifts on coef_en.
module fir_coef_path #(
    parameter int unsigned COEF_W  = fir_cell_pkg::COEF_W_DEF,
    parameter int unsigned DEC_MAX = fir_cell_pkg::DEC_MAX_DEF,
    localparam int unsigned MODE_W = $clog2(DEC_MAX + 1)
) (
    input  logic              clk,
    input  logic              coef_en,
    input  logic              pipe_clr,
    input  logic [MODE_W-1:0] dec_mode,
    input  logic [COEF_W-1:0] coef_in,
    output logic [COEF_W-1:0] mult_coef,
    output logic [COEF_W-1:0] coef_out
);
    logic [COEF_W-1:0] stage [0:DEC_MAX];

    // Coefficient register: clear, load or hold
    always_ff @(posedge clk) begin
        if (pipe_clr)     stage[0] <= '0;
        else if (coef_en) stage[0] <= coef_in;
    end

    genvar g;
    generate
        for (g = 1; g <= DEC_MAX; g++) begin : g_dec
            // One decimation delay stage
            always_ff @(posedge clk) begin
                if (pipe_clr)     stage[g] <= '0;
                else if (coef_en) stage[g] <= stage[g-1];
            end
        end
    endgenerate

    // Multiplier reads the coefficient register; the mode picks the exit tap
    assign mult_coef = stage[0];
    assign coef_out  = stage[dec_mode];
endmodule

// File: rtl/fir_mac_unit.sv
// Module: data register, operand extension, multiplier and wrapping accumulator.
// Assumes: ACC_W exceeds the product width; the accumulator has no reset.
module fir_mac_unit #(
    parameter int unsigned COEF_W = fir_cell_pkg::COEF_W_DEF,
    parameter int unsigned DATA_W = fir_cell_pkg::DATA_W_DEF,
    parameter int unsigned ACC_W  = fir_cell_pkg::ACC_W_DEF,
    localparam int unsigned PROD_W = COEF_W + DATA_W + 2
) (
    input  logic              clk,
    input  logic              data_en,
    input  logic              pipe_clr,
    input  logic              coef_signed,
    input  logic              data_signed,
    input  logic [COEF_W-1:0] mult_coef,
    input  logic [DATA_W-1:0] data_in,
    input  logic              acc_restart,
    output logic [ACC_W-1:0]  acc_out
);
    logic [DATA_W-1:0]        data_q;
    logic signed [COEF_W:0]   c_ext;
    logic signed [DATA_W:0]   d_ext;
    logic signed [PROD_W-1:0] prod;
    logic [ACC_W-1:0]         prod_acc;
    logic [ACC_W-1:0]         acc_q;

    // Data register: clear, load or hold
    always_ff @(posedge clk) begin
        if (pipe_clr)     data_q <= '0;
        else if (data_en) data_q <= data_in;
    end

    // Extend each operand to one extra bit, signed or unsigned per mode
    always_comb begin
        c_ext = coef_signed ? {mult_coef[COEF_W-1], mult_coef}
                            : {2'b00, mult_coef[COEF_W-2:0]};
        d_ext = data_signed ? {data_q[DATA_W-1], data_q}
                            : {2'b00, data_q[DATA_W-2:0]};
        prod     = c_ext * d_ext;
        prod_acc = {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
    end

    // Accumulator: restart with the product or add it, wrapping
    always_ff @(posedge clk) begin
        if (acc_restart) acc_q <= prod_acc;
        else             acc_q <= acc_q + prod_acc;
    end

    assign acc_out = acc_q;
endmodule

// File: rtl/fir_mac_cell.sv
// Module: top of one decimating FIR tap cell.
// Assumes: erase_n and cell_sel act on the same edge; the other controls are delayed one clock.
module fir_mac_cell
    import fir_cell_pkg::*;
#(
    parameter int unsigned COEF_W  = COEF_W_DEF,
    parameter int unsigned DATA_W  = DATA_W_DEF,
    parameter int unsigned ACC_W   = ACC_W_DEF,
    parameter int unsigned DEC_MAX = DEC_MAX_DEF,
    localparam int unsigned MODE_W = $clog2(DEC_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              coef_ld_n,
    input  logic              data_ld_n,
    input  logic              coef_signed,
    input  logic              data_signed,
    input  logic [MODE_W-1:0] dec_mode,
    input  logic [COEF_W-1:0] coef_in,
    input  logic [DATA_W-1:0] data_in,
    input  logic              erase_n,
    input  logic              cell_sel,
    output logic [COEF_W-1:0] coef_out,
    output logic [ACC_W-1:0]  acc_out
);
    cell_ctrl_t        ctrl;
    logic [COEF_W-1:0] mult_coef;
    logic              acc_restart;

    // Erase applies to the selected cell, or to every cell while reset is low
    assign acc_restart = ~erase_n & (cell_sel | ~rst_n);

    fir_ctrl_pipe u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .coef_ld_n(coef_ld_n),
        .data_ld_n(data_ld_n),
        .ctrl     (ctrl)
    );

    fir_coef_path #(.COEF_W(COEF_W), .DEC_MAX(DEC_MAX)) u_coef (
        .clk      (clk),
        .coef_en  (ctrl.coef_en),
        .pipe_clr (ctrl.pipe_clr),
        .dec_mode (dec_mode),
        .coef_in  (coef_in),
        .mult_coef(mult_coef),
        .coef_out (coef_out)
    );

    fir_mac_unit #(.COEF_W(COEF_W), .DATA_W(DATA_W), .ACC_W(ACC_W)) u_mac (
        .clk        (clk),
        .data_en    (ctrl.data_en),
        .pipe_clr   (ctrl.pipe_clr),
        .coef_signed(coef_signed),
        .data_signed(data_signed),
        .mult_coef  (mult_coef),
        .data_in    (data_in),
        .acc_restart(acc_restart),
        .acc_out    (acc_out)
    );
endmodule

// File: rtl/fir_mac_cell_chk.sv
// Module: protocol checks on the cell ports, attached to every fir_mac_cell by bind.
// Assumes: all inputs are driven from time zero.
module fir_mac_cell_chk #(
    parameter int unsigned COEF_W = 9,
    parameter int unsigned ACC_W  = 26,
    parameter int unsigned MODE_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              coef_ld_n,
    input logic              erase_n,
    input logic              cell_sel,
    input logic [MODE_W-1:0] dec_mode,
    input logic [COEF_W-1:0] coef_out,
    input logic [ACC_W-1:0]  acc_out
);
    // R4: a coefficient enable sampled high freezes the coefficient output
    a_r4_coef_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(coef_ld_n) && $past(rst_n)) |=> (!$stable(dec_mode) || $stable(coef_out)));

    // R6: after reset is released, every coefficient stage reads zero
    a_r6_pipe_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |=> (coef_out == '0));

    // R7: erase of the selected cell with a zero coefficient leaves zero
    a_r7_erase_sel: assert property (@(posedge clk) disable iff (!rst_n)
        (!erase_n && cell_sel && dec_mode == '0 && coef_out == '0) |=> (acc_out == '0));

    // R9: a zero coefficient adds nothing to the accumulator
    a_r9_zero_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_n && dec_mode == '0 && coef_out == '0) |=> $stable(acc_out));
endmodule

bind fir_mac_cell fir_mac_cell_chk #(.COEF_W(COEF_W), .ACC_W(ACC_W), .MODE_W(MODE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .coef_ld_n(coef_ld_n),
    .erase_n  (erase_n),
    .cell_sel (cell_sel),
    .dec_mode (dec_mode),
    .coef_out (coef_out),
    .acc_out  (acc_out)
);

// File: tb/tb_fir_mac_cell.sv
module tb_fir_mac_cell;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0, coef_ld_n = 1'b1, data_ld_n = 1'b1;
    logic        coef_signed = 1'b1, data_signed = 1'b1;
    logic [1:0]  dec_mode = 2'd0;
    logic [8:0]  coef_in = '0, data_in = '0;
    logic        erase_n = 1'b0, cell_sel = 1'b0;
    logic [8:0]  coef_out;
    logic [25:0] acc_out;

    int errors = 0, checks = 0;
    bit chk_on = 1'b0;
    bit done = 1'b0;
    string cur_req = "R6";

    // reference state
    logic [8:0]  m_c = '0, m_d1 = '0, m_d2 = '0, m_d3 = '0, m_x = '0;
    logic [25:0] m_acc = '0;
    logic        m_ce = 1'b0, m_de = 1'b0, m_clr = 1'b1;

    always #4 clk = ~clk;

    fir_mac_cell dut (
        .clk(clk), .rst_n(rst_n), .coef_ld_n(coef_ld_n), .data_ld_n(data_ld_n),
        .coef_signed(coef_signed), .data_signed(data_signed), .dec_mode(dec_mode),
        .coef_in(coef_in), .data_in(data_in), .erase_n(erase_n), .cell_sel(cell_sel),
        .coef_out(coef_out), .acc_out(acc_out)
    );

    function automatic logic signed [25:0] ext_op(logic [8:0] v, logic s);
        return s ? 26'(signed'(v)) : 26'({18'd0, v[7:0]});
    endfunction

    function automatic logic [25:0] ref_prod(logic [8:0] c, logic [8:0] x, logic cs, logic xs);
        logic signed [25:0] a, b;
        a = ext_op(c, cs);
        b = ext_op(x, xs);
        return a * b;
    endfunction

    function automatic logic [8:0] exp_coef();
        case (dec_mode)
            2'd0: return m_c;
            2'd1: return m_d1;
            2'd2: return m_d2;
            default: return m_d3;
        endcase
    endfunction

    // Reference model update from the requirements
    always @(posedge clk) begin
        logic [25:0] p;
        p = ref_prod(m_c, m_x, coef_signed, data_signed);
        if (!erase_n && (cell_sel || !rst_n)) m_acc = p;
        else m_acc = m_acc + p;
        if (m_clr) begin
            m_c = '0; m_d1 = '0; m_d2 = '0; m_d3 = '0; m_x = '0;
        end else begin
            if (m_ce) begin m_d3 = m_d2; m_d2 = m_d1; m_d1 = m_c; m_c = coef_in; end
            if (m_de) m_x = data_in;
        end
        m_ce = !coef_ld_n; m_de = !data_ld_n; m_clr = !rst_n;
    end

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        if (chk_on) begin
            check(coef_out == exp_coef(), {cur_req, " coef"}, 32'(coef_out), 32'(exp_coef()));
            check(acc_out == m_acc, {cur_req, " acc"}, 32'(acc_out), 32'(m_acc));
        end
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic load_cx(logic [8:0] c, logic [8:0] x);
        erase_n = 1'b1; cell_sel = 1'b0; dec_mode = 2'd0;
        coef_ld_n = 1'b0; data_ld_n = 1'b0; coef_in = c; data_in = x;
        ticks(2);
        coef_ld_n = 1'b1; data_ld_n = 1'b1;
        ticks(2);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 8);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        logic [25:0] a_before;
        logic [8:0]  hold_v;
        int n;
        void'($urandom(32'd20240611));
        // reset with erase: everything clears (R6, R8)
        ticks(4);
        check(coef_out == 9'd0, "R6 reset coef", 32'(coef_out), 0);
        check(acc_out == 26'd0, "R8 reset acc", 32'(acc_out), 0);
        chk_on = 1'b1;
        rst_n = 1'b1; erase_n = 1'b1;
        ticks(2);

        // R3: decimation delay per mode
        cur_req = "R3";
        for (int m = 0; m < 4; m++) begin
            dec_mode = 2'(m); coef_ld_n = 1'b0; coef_in = '0;
            ticks(5);
            coef_in = 9'h0A5 + 9'(m);
            tick();
            coef_in = '0;
            n = 1;
            while (coef_out != 9'h0A5 + 9'(m) && n < 8) begin tick(); n++; end
            check(n == m + 1, "R3 delay", 32'(n), 32'(m + 1));
        end

        // R4: hold while high, load on second edge
        cur_req = "R4";
        dec_mode = 2'd0; coef_ld_n = 1'b1;
        ticks(2);
        hold_v = coef_out;
        coef_in = ~hold_v;
        tick();
        check(coef_out == hold_v, "R4 hold", 32'(coef_out), 32'(hold_v));
        coef_ld_n = 1'b0;
        tick();
        check(coef_out == hold_v, "R4 first edge", 32'(coef_out), 32'(hold_v));
        tick();
        check(coef_out == ~hold_v, "R4 second edge", 32'(coef_out), 32'(~hold_v));

        // R5: data enable delay, seen through the accumulator with coefficient 1
        cur_req = "R5";
        load_cx(9'd1, 9'd7);
        data_in = 9'd9; erase_n = 1'b0; cell_sel = 1'b1;
        tick();
        check(acc_out == 26'd7, "R5 hold", 32'(acc_out), 7);
        data_ld_n = 1'b0;
        ticks(2);
        check(acc_out == 26'd7, "R5 before load", 32'(acc_out), 7);
        tick();
        check(acc_out == 26'd9, "R5 loaded", 32'(acc_out), 9);
        data_ld_n = 1'b1; erase_n = 1'b1; cell_sel = 1'b0;

        // R6: reset clears registers one clock late, accumulator untouched
        cur_req = "R6";
        load_cx(9'h055, 9'd0);
        a_before = acc_out;
        rst_n = 1'b0;
        tick();
        check(coef_out == 9'h055, "R6 delayed", 32'(coef_out), 32'h55);
        rst_n = 1'b1;
        tick();
        check(coef_out == 9'd0, "R6 cleared", 32'(coef_out), 0);
        check(acc_out == a_before, "R6 acc kept", 32'(acc_out), 32'(a_before));

        // R7: erase needs select
        cur_req = "R7";
        load_cx(9'd3, 9'd5);
        a_before = acc_out;
        erase_n = 1'b0; cell_sel = 1'b0;
        tick();
        check(acc_out == a_before + 26'd15, "R7 unselected", 32'(acc_out), 32'(a_before + 26'd15));
        cell_sel = 1'b1;
        tick();
        check(acc_out == 26'd15, "R7 selected", 32'(acc_out), 15);
        erase_n = 1'b1;
        tick();
        check(acc_out == 26'd30, "R9 accumulate", 32'(acc_out), 30);

        // R8: erase with reset ignores select
        cur_req = "R8";
        cell_sel = 1'b0; erase_n = 1'b0; rst_n = 1'b0;
        tick();
        check(acc_out == 26'd15, "R8 erase with reset", 32'(acc_out), 15);
        rst_n = 1'b1; erase_n = 1'b1;
        ticks(2);

        // R2: operand interpretation
        cur_req = "R2";
        load_cx(9'h1FF, 9'h003);
        erase_n = 1'b0; cell_sel = 1'b1;
        tick();
        check(acc_out == 26'h3FFFFFD, "R2 signed x signed", 32'(acc_out), 32'h3FFFFFD);
        coef_signed = 1'b0;
        tick();
        check(acc_out == 26'd765, "R2 unsigned coef", 32'(acc_out), 765);
        coef_signed = 1'b1;
        load_cx(9'h1FF, 9'h1FE);
        erase_n = 1'b0; cell_sel = 1'b1; data_signed = 1'b0;
        tick();
        check(acc_out == 26'h3FFFF02, "R2 unsigned data", 32'(acc_out), 32'h3FFFF02);
        data_signed = 1'b1;

        // R1: wrap modulo 2^26
        cur_req = "R1";
        load_cx(9'h100, 9'h100);
        erase_n = 1'b0; cell_sel = 1'b1;
        tick();
        check(acc_out == 26'd65536, "R1 start", 32'(acc_out), 65536);
        erase_n = 1'b1;
        ticks(511);
        check(acc_out == 26'h2000000, "R1 half", 32'(acc_out), 32'h2000000);
        ticks(512);
        check(acc_out == 26'd0, "R1 wrap", 32'(acc_out), 0);

        // R9 and all interactions: seeded random traffic against the model
        cur_req = "R9";
        for (int i = 0; i < 3000; i++) begin
            rst_n       = ($urandom % 40) != 0;
            coef_ld_n   = ($urandom % 4) == 0;
            data_ld_n   = ($urandom % 4) == 0;
            erase_n     = ($urandom % 8) != 0;
            cell_sel    = $urandom % 2;
            coef_signed = $urandom % 2;
            data_signed = $urandom % 2;
            dec_mode    = 2'($urandom);
            coef_in     = 9'($urandom);
            data_in     = 9'($urandom);
            tick();
        end
        finish_run();
    end
endmodule